// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a system that must prove it is still alive. A 12-bit down counter advances at 256 steps per second of a 32768 Hz slow clock. Software has to restart it in time by writing a keyed command, and it must not do so too early. If the counter runs out, or software restarts it while it is still above a programmed window value, the block records a fault. It then raises a fault interrupt and/or a reset request, depending on its mode. The whole block runs on one fabric clock. The slow clock arrives as a one-cycle enable pulse, `slow_en`, once per slow clock period.

Software sees three word registers through a simple write/read port. The control register (address 0) takes restart commands. The mode register (address 1) holds the configuration. The status register (address 2) reports faults and clears them when read. Any write to the mode register also restarts the counter. After each restart, writes to the control and mode registers are ignored for a short number of slow clock periods. The counter can be stopped by a disable bit. It can also be frozen while the system is idle or halted by a debugger.

Top module: `winwdt`

## Requirements
- R1: After a restart with reload value N, and with the counter running and `slow_en` high every cycle, the underflow fault is recorded exactly (N+1)*PRESCALE clock edges later. The counter then reloads N and keeps counting. PRESCALE defaults to 128, which gives 256 counts per second at 32768 Hz.
- R2: A write to address 0 restarts the counter only when bits 31:24 hold 0xA5 and bit 0 is 1. Any other control write has no effect.
- R3: A write to the mode register reloads the counter from the reload field it writes and restarts the slow-clock prescaler.
- R4: For LOCK_SLOW `slow_en` pulses after any restart (default 3), writes to address 0 and address 1 are ignored entirely.
- R5: Mode register layout: reload in bits 11:0, interrupt enable in bit 12, reset-request enable in bit 13, disable in bit 15, window in bits 27:16, idle-freeze enable in bit 28, debug-freeze enable in bit 29. While the stored disable bit is 1, the counter does not move and mode writes leave the reload and window fields unchanged.
- R6: A fault sets a status flag. While any flag is set, `fault_irq` is high if interrupt enable is set, and `reset_req` is high if reset-request enable is set. Both outputs are registered.
- R7: The counter and prescaler hold their values while `idle_in` is high with idle-freeze enabled, and likewise while `dbg_in` is high with debug-freeze enabled.
- R8: A keyed restart taken while enabled and with the counter above the window field sets status bit 1 and raises the same fault outputs as an underflow. With the window at 0xFFF, a restart never faults.
- R9: A read returns data on `rdata` one cycle after `rd_en`: the mode register at address 1, or the status register (bit 0 underflow, bit 1 window error) at address 2. Reading status clears both flags unless a new fault arrives in the same cycle.
- R10: After reset the mode register reads 0x0FFF8FFF: disabled, reload and window at 0xFFF, everything else 0. The status register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_en | input | 1 | One pulse per slow clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| idle_in | input | 1 | System idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| fault_irq | output | 1 | Fault interrupt, level |
| reset_req | output | 1 | Reset request to the system reset controller |

## Verification
The bench aims at the ordering rules between restarts and writes.

- A mode write arriving during the post-restart lockout must not land. A design that accepted it would read back the new configuration.
- A reload change written while disabled must be dropped. A design that took it would read back the new reload value.
- An early keyed restart must produce the window error. A wrong-key write must produce nothing. A design that compared the wrong byte, or skipped the window check, would miss or invent a status bit.

The exact expiry distance after a mode write, and after the idle freeze is released, is timed to the clock edge. An off-by-one in the prescaler or the underflow test shifts the interrupt by whole prescaler periods.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 8;

  localparam logic [KEY_W-1:0] RESTART_KEY = 8'hA5;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // Bit positions of the mode word.
  localparam int RELOAD_LSB = 0;
  localparam int IRQ_BIT    = 12;
  localparam int RST_BIT    = 13;
  localparam int DIS_BIT    = 15;
  localparam int WIN_LSB    = 16;
  localparam int IDLE_BIT   = 28;
  localparam int DBG_BIT    = 29;
  localparam int KEY_LSB    = DATA_W - KEY_W;

  typedef struct packed {
    logic             dbg_en;
    logic             idle_en;
    logic [CNT_W-1:0] window;
    logic             dis;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam mode_t MODE_RESET = '{
    dbg_en:  1'b0,
    idle_en: 1'b0,
    window:  {CNT_W{1'b1}},
    dis:     1'b1,
    rst_en:  1'b0,
    irq_en:  1'b0,
    reload:  {CNT_W{1'b1}}
  };

  function automatic mode_t mode_from_word(input logic [DATA_W-1:0] w);
    mode_t m;
    m.reload  = w[RELOAD_LSB +: CNT_W];
    m.irq_en  = w[IRQ_BIT];
    m.rst_en  = w[RST_BIT];
    m.dis     = w[DIS_BIT];
    m.window  = w[WIN_LSB +: CNT_W];
    m.idle_en = w[IDLE_BIT];
    m.dbg_en  = w[DBG_BIT];
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
    logic [DATA_W-1:0] w;
    w                        = '0;
    w[RELOAD_LSB +: CNT_W]   = m.reload;
    w[IRQ_BIT]               = m.irq_en;
    w[RST_BIT]               = m.rst_en;
    w[DIS_BIT]               = m.dis;
    w[WIN_LSB +: CNT_W]      = m.window;
    w[IDLE_BIT]              = m.idle_en;
    w[DBG_BIT]               = m.dbg_en;
    return w;
  endfunction
endpackage

// File: rtl/winwdt_prescale.sv
module winwdt_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = step;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] pre;
      logic         wrap;

      assign wrap = (pre == W'(DIV - 1));
      assign tick = step && wrap;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pre <= '0;
        end else if (step) begin
          pre <= wrap ? '0 : pre + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/winwdt_lock.sv
module winwdt_lock #(
  parameter int SLOW_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic slow_en,
  output logic busy
);
  localparam int W = $clog2(SLOW_N + 1);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= W'(SLOW_N);
    end else if (slow_en && left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/winwdt_down.sv
module winwdt_down #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         underflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
    end
  end

  assign underflow = tick && !load && (cnt == '0);
endmodule

// File: rtl/winwdt.sv
module winwdt
  import winwdt_pkg::*;
#(
  parameter int PRESCALE  = 128,
  parameter int LOCK_SLOW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              idle_in,
  input  logic              dbg_in,
  output logic              fault_irq,
  output logic              reset_req
);
  mode_t             mode_q, mode_wr_val, mode_d;
  logic [DATA_W-1:0] mode_word_q;
  logic              lock_busy, key_ok, mode_hit, restart, win_err;
  logic              run, step, tick, underflow, stat_rd;
  logic [CNT_W-1:0]  cnt, load_val;
  logic [1:0]        sts_q, sts_d;

  assign mode_word_q = mode_to_word(mode_q);

  always_comb begin
    key_ok   = wr_en && (addr == A_CTRL) && !lock_busy
               && (wdata[KEY_LSB +: KEY_W] == RESTART_KEY) && wdata[0];
    mode_hit = wr_en && (addr == A_MODE) && !lock_busy;

    mode_wr_val = mode_from_word(wdata);
    if (mode_q.dis) begin
      mode_wr_val.reload = mode_q.reload;
      mode_wr_val.window = mode_q.window;
    end
    mode_d   = mode_hit ? mode_wr_val : mode_q;
    load_val = mode_hit ? mode_wr_val.reload : mode_q.reload;

    restart = key_ok || mode_hit;
    win_err = key_ok && !mode_q.dis && (cnt > mode_q.window);

    run  = !mode_q.dis
           && !(idle_in && mode_q.idle_en)
           && !(dbg_in && mode_q.dbg_en);
    step = slow_en && run;

    stat_rd = rd_en && (addr == A_STAT);
    sts_d   = (stat_rd ? 2'b00 : sts_q) | {win_err, underflow};
  end

  winwdt_prescale #(.DIV(PRESCALE)) i_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .step (step),
    .tick (tick)
  );

  winwdt_lock #(.SLOW_N(LOCK_SLOW)) i_lock (
    .clk     (clk),
    .rst     (rst),
    .start   (restart),
    .slow_en (slow_en),
    .busy    (lock_busy)
  );

  winwdt_down #(.W(CNT_W)) i_down (
    .clk        (clk),
    .rst        (rst),
    .load       (restart),
    .load_val   (load_val),
    .reload_val (mode_q.reload),
    .tick       (tick),
    .cnt        (cnt),
    .underflow  (underflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RESET;
      sts_q     <= 2'b00;
      fault_irq <= 1'b0;
      reset_req <= 1'b0;
      rdata     <= '0;
    end else begin
      mode_q    <= mode_d;
      sts_q     <= sts_d;
      fault_irq <= mode_d.irq_en && (sts_d != 2'b00);
      reset_req <= mode_d.rst_en && (sts_d != 2'b00);
      if (rd_en) begin
        case (addr)
          A_MODE:  rdata <= mode_word_q;
          A_STAT:  rdata <= {{(DATA_W-2){1'b0}}, sts_q};
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk
  import winwdt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              lock_busy,
  input logic [DATA_W-1:0] mode_word,
  input logic [CNT_W-1:0]  cnt,
  input logic              restart,
  input logic              idle_in,
  input logic              dbg_in,
  input logic              underflow,
  input logic [1:0]        sts,
  input logic              fault_irq
);
  // R4: a mode write inside the lockout leaves the mode register untouched
  p_mode_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_busy && wr_en && addr == A_MODE) |=> $stable(mode_word));

  // R5: a disabled counter holds unless it is reloaded
  p_disabled_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_word[DIS_BIT] && !restart) |=> $stable(cnt));

  // R6: an underflow leaves the underflow flag set
  p_uf_flag_r6: assert property (@(posedge clk) disable iff (rst)
    underflow |=> sts[0]);

  // R6: the interrupt needs both its enable and a pending flag
  p_irq_enable_r6: assert property (@(posedge clk) disable iff (rst)
    fault_irq |-> (mode_word[IRQ_BIT] && sts != 2'b00));

  // R7: idle freeze
  p_idle_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (idle_in && mode_word[IDLE_BIT] && !restart) |=> $stable(cnt));

  // R7: debug freeze
  p_dbg_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (dbg_in && mode_word[DBG_BIT] && !restart) |=> $stable(cnt));
endmodule

bind winwdt winwdt_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .lock_busy (lock_busy),
  .mode_word (mode_word_q),
  .cnt       (cnt),
  .restart   (restart),
  .idle_in   (idle_in),
  .dbg_in    (dbg_in),
  .underflow (underflow),
  .sts       (sts_q),
  .fault_irq (fault_irq)
);

// File: tb/test_winwdt.sv
module test_winwdt;
  localparam int P = 4;
  localparam logic [31:0] MASK       = 32'h3FFF_BFFF;
  localparam logic [31:0] RESET_MODE = 32'h0FFF_8FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_en = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        idle_in = 1'b0, dbg_in = 1'b0;
  logic        fault_irq, reset_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  winwdt #(.PRESCALE(P), .LOCK_SLOW(3)) i_winwdt (
    .clk (clk), .rst (rst), .slow_en (slow_en), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .idle_in (idle_in),
    .dbg_in (dbg_in), .fault_irq (fault_irq), .reset_req (reset_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  logic [31:0] m_mode, m_rdata, nm, mode_n;
  logic [11:0] m_cnt;
  logic [1:0]  m_pre, m_lock, m_sts, sts_n;
  logic        m_irq, m_rst;
  logic        busy_m, mw, cw, run_m, rs_m, werr, tk, uf;

  always @(posedge clk) begin
    if (rst) begin
      m_mode <= RESET_MODE; m_cnt <= 12'hFFF; m_pre <= 0; m_lock <= 0;
      m_sts <= 0; m_irq <= 0; m_rst <= 0; m_rdata <= 0;
    end else begin
      busy_m = (m_lock != 0);
      mw = wr_en && addr == 2'd1 && !busy_m;
      cw = wr_en && addr == 2'd0 && !busy_m && wdata[31:24] == 8'hA5 && wdata[0];
      nm = wdata & MASK;
      if (m_mode[15]) begin
        nm[11:0]  = m_mode[11:0];
        nm[27:16] = m_mode[27:16];
      end
      run_m = !m_mode[15] && !(idle_in && m_mode[28]) && !(dbg_in && m_mode[29]);
      rs_m  = mw || cw;
      werr  = cw && !m_mode[15] && (m_cnt > m_mode[27:16]);
      tk    = !rs_m && run_m && slow_en && m_pre == 2'(P - 1);
      uf    = tk && m_cnt == 0;
      mode_n = mw ? nm : m_mode;
      sts_n  = ((rd_en && addr == 2'd2) ? 2'b00 : m_sts) | {werr, uf};
      if (rs_m) m_pre <= 0;
      else if (run_m && slow_en) m_pre <= (m_pre == 2'(P - 1)) ? 2'd0 : m_pre + 1;
      if (rs_m) m_cnt <= mw ? nm[11:0] : m_mode[11:0];
      else if (tk) m_cnt <= (m_cnt == 0) ? m_mode[11:0] : m_cnt - 1;
      if (rs_m) m_lock <= 2'd3;
      else if (slow_en && m_lock != 0) m_lock <= m_lock - 1;
      m_mode <= mode_n;
      m_sts  <= sts_n;
      m_irq  <= mode_n[12] && sts_n != 0;
      m_rst  <= mode_n[13] && sts_n != 0;
      if (rd_en)
        m_rdata <= (addr == 2'd1) ? m_mode : (addr == 2'd2) ? {30'b0, m_sts} : 32'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(fault_irq === m_irq, "R6 fault_irq vs model", {31'b0, fault_irq}, {31'b0, m_irq});
      chk(reset_req === m_rst, "R6 reset_req vs model", {31'b0, reset_req}, {31'b0, m_rst});
      chk(rdata === m_rdata, "R9 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic tick1();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick1();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick1();
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int first;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(2'd1, d); chk(d == RESET_MODE, "R10 mode after reset", d, RESET_MODE);
    rd(2'd2, d); chk(d == 0, "R10 status after reset", d, 0);

    // R5: the reload change is dropped while the disable bit is stored
    wr(2'd1, 32'h0FFF_3005);
    rd(2'd1, d); chk(d == 32'h0FFF_3FFF, "R5 reload kept while disabled", d, 32'h0FFF_3FFF);
    idle(4);

    // R1 R3: expiry distance after a mode write
    wr(2'd1, 32'h0FFF_3005);
    first = 0;
    for (int n = 1; n <= 40; n++) begin
      tick1();
      if (fault_irq && first == 0) first = n;
    end
    chk(first == 24, "R1 R3 underflow distance", first, 24);
    chk(reset_req == 1'b1, "R6 reset_req on underflow", {31'b0, reset_req}, 1);
    rd(2'd2, d); chk(d == 32'h1, "R6 underflow flag", d, 1);
    rd(2'd2, d); chk(d == 32'h0, "R9 status cleared by read", d, 0);
    chk(fault_irq == 1'b0, "R9 irq drops after clear", {31'b0, fault_irq}, 0);

    // R2 R8 R4: window and key
    idle(4);
    wr(2'd1, 32'h0002_3032);
    idle(4);
    rd(2'd2, d);
    wr(2'd0, 32'h5A00_0001);
    rd(2'd2, d); chk(d == 0, "R2 wrong key ignored", d, 0);
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d); chk(d == 32'h2, "R8 early restart flags window error", d, 2);
    wr(2'd1, 32'h0002_0032);
    rd(2'd1, d); chk(d == 32'h0002_3032, "R4 mode write in lockout ignored", d, 32'h0002_3032);
    idle(4);
    wr(2'd1, 32'h0FFF_3032);
    idle(4);
    rd(2'd2, d);
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, d); chk(d == 0, "R8 full window restart legal", d, 0);

    // R7: idle freeze
    idle(4);
    idle_in = 1'b1;
    wr(2'd1, 32'h1FFF_1003);
    idle(4);
    rd(2'd2, d);
    idle(100);
    chk(fault_irq == 1'b0, "R7 no expiry while frozen", {31'b0, fault_irq}, 0);
    rd(2'd2, d); chk(d == 0, "R7 status while frozen", d, 0);
    idle_in = 1'b0;
    first = 0;
    for (int n = 1; n <= 30; n++) begin
      tick1();
      if (fault_irq && first == 0) first = n;
    end
    chk(first == 16, "R7 expiry after release", first, 16);

    // R5: disabled counter stops
    idle(4);
    wr(2'd1, 32'h0FFF_9003);
    idle(4);
    rd(2'd2, d);
    idle(60);
    chk(fault_irq == 1'b0, "R5 no expiry while disabled", {31'b0, fault_irq}, 0);
    rd(2'd2, d); chk(d == 0, "R5 status while disabled", d, 0);
    wr(2'd1, 32'h0FFF_9007);
    rd(2'd1, d); chk(d == 32'h0FFF_9003, "R5 reload write dropped", d, 32'h0FFF_9003);

    // Random phase, checked against the model (R1 to R9)
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom % 16);
      slow_en = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) idle_in = ~idle_in;
      if ($urandom % 8 == 0) dbg_in  = ~dbg_in;
      wr_en = 1'b0; rd_en = 1'b0;
      if (r == 0) begin
        wr_en = 1'b1; addr = 2'd1;
        wdata = $urandom;
        wdata[11:0]  = 12'($urandom % 12);
        wdata[27:16] = ($urandom % 2 == 0) ? 12'hFFF : 12'($urandom % 12);
        wdata[15]    = ($urandom % 4 == 0);
      end else if (r == 1) begin
        wr_en = 1'b1; addr = 2'd0;
        wdata = $urandom;
        if ($urandom % 4 != 0) begin
          wdata[31:24] = 8'hA5;
          wdata[0] = 1'b1;
        end
      end else if (r == 2 || r == 3) begin
        rd_en = 1'b1;
        addr = (r == 2) ? 2'd2 : 2'd1;
      end
      tick1();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule